// File: doc/BRIEF.md
# Watchdog Timer with Shared Ratio Divider

This block is a watchdog whose slow time base can be extended by an 8-bit binary divider. The same divider also serves a general-purpose timer as an input prescaler. One option bit gives the divider to one side or the other. Three ratio bits set how many events it merges into one. Whichever side does not own the divider runs at 1:1.

The watchdog advances on single-cycle ticks from its own slow oscillator. These ticks arrive already synchronized to `clk`. The count continues while the core is asleep. When the period runs out, the block pulses one of two outputs. Outside sleep it pulses a reset request, and during sleep it pulses a wake request. It also drops an active-high "no time-out seen" flag. Firmware keeps the watchdog quiet with a clear strobe. Entering sleep restarts the period in the same way, so the full period is available before a wake.

The block has no streaming data path, so every pin is a plain level or a single-cycle strobe with no back-pressure. All outputs are registered. A result appears one clock after the input event that causes it.

Top module: `wdog_shared_div`

## Requirements
- R1: After reset, `wdt_reset`, `wdt_wake` and `tmr_tick_out` are 0, `no_timeout` is 1, and both the divider and the base counter are zero.
- R2: `opt_div_to_wdt`=1 gives the divider to the watchdog. `opt_div_to_wdt`=0 gives it to the timer. When the divider belongs to the watchdog, every `tmr_in_tick` produces `tmr_tick_out` one cycle later.
- R3: With the divider on the timer, ratio code r (0..7) produces one `tmr_tick_out` per 2^(r+1) `tmr_in_tick` events, from 1:2 up to 1:256. The pulse comes one cycle after the qualifying input event. No input event means no output.
- R4: The base period is BASE_TICKS `wdt_tick` events. With the divider on the watchdog, ratio code r stretches the time-out to BASE_TICKS*2^r ticks (1:1 up to 1:128). With the divider on the timer, the time-out is BASE_TICKS ticks.
- R5: `clr_wdt` zeroes the base counter. It also zeroes the divider, but only when the watchdog owns it. A divider owned by the timer keeps its partial count.
- R6: `sleep_enter` has the same clearing effect as `clr_wdt`.
- R7: While `cfg_wdt_en` is 0, no time-out pulse is ever produced and the base counter is held at zero. Timer prescaling is unaffected.
- R8: A time-out gives a one-cycle `wdt_reset` if `in_sleep` was 0 on the final tick, or a one-cycle `wdt_wake` if it was 1, one cycle after that tick. Counting proceeds the same whatever `in_sleep` is.
- R9: `no_timeout` goes to 0 together with either time-out pulse. It returns to 1 one cycle after `clr_wdt` or `sleep_enter`.
- R10: A change of `opt_div_to_wdt` zeroes the divider in the cycle the new value is first seen. Divider-side events in that cycle are not counted.
- R11: After a time-out both counters restart from zero, so the next time-out needs a full period.
- R12: A clear strobe in the same cycle as a `wdt_tick` wins: that tick is not counted and cannot cause a time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdt_en | input | 1 | Watchdog enable from configuration; 0 disables it |
| opt_div_to_wdt | input | 1 | Divider owner: 1 watchdog, 0 timer |
| opt_ratio | input | 3 | Division ratio code |
| wdt_tick | input | 1 | One-cycle tick from the watchdog's slow oscillator |
| tmr_in_tick | input | 1 | One-cycle timer count event |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_enter | input | 1 | Sleep-entry strobe |
| in_sleep | input | 1 | Core is asleep |
| tmr_tick_out | output | 1 | Prescaled timer tick |
| wdt_reset | output | 1 | Time-out reset request pulse (awake) |
| wdt_wake | output | 1 | Time-out wake request pulse (asleep) |
| no_timeout | output | 1 | 1 until a time-out occurs; set again by a clear |

## Verification
Several properties are checked on every cycle:
- Time-out pulses last one cycle and never occur together.
- The choice between reset and wake follows the sleep flag on the final tick.
- A disabled watchdog stays silent.
- A clear strobe both restores the flag and suppresses a pulse.
- Timer ticks pass straight through while the watchdog owns the divider, and no timer pulse appears without an input event.

Some behaviours need multi-cycle scenarios in the bench:
- the exact tick counts of each ratio on each side;
- whether a clear reaches the divider, depending on which side owns it;
- the clearing of the divider on an owner change;
- the restart after a time-out;
- a clear colliding with a tick.

// File: rtl/wdsd_pkg.sv
`timescale 1ns/1ps
package wdsd_pkg;
  // Owner of the shared divider, as coded on opt_div_to_wdt.
  typedef enum logic {
    OWNER_TIMER = 1'b0,
    OWNER_WDOG  = 1'b1
  } div_owner_e;

  // Mask with the k lowest bits set, for a counter of width w.
  function automatic logic [15:0] low_mask(input int unsigned k, input int unsigned w);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < k && i < w) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wdsd_base_cnt.sv
`timescale 1ns/1ps
module wdsd_base_cnt #(
  parameter int BASE_TICKS = 18,
  localparam int CW = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  // One base period ends on the tick that finds the counter at its last value.
  assign done = en && tick && !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdsd_divider.sv
`timescale 1ns/1ps
module wdsd_divider
  import wdsd_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int KW = $clog2(DIV_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  input  logic [KW-1:0] k,
  output logic          hit
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    logic [15:0] m16;
    m16  = low_mask(32'(k), DIV_W);
    mask = m16[DIV_W-1:0];
  end

  // A 1:2^k output fires on the event that rolls the low k bits over.
  assign hit = inc && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdsd_timeout_gen.sv
`timescale 1ns/1ps
module wdsd_timeout_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic asleep,
  input  logic clr_any,
  output logic rst_pulse,
  output logic wake_pulse,
  output logic no_to_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
      no_to_flag <= 1'b1;
    end else begin
      rst_pulse  <= timeout && !asleep;
      wake_pulse <= timeout && asleep;
      if (timeout)      no_to_flag <= 1'b0;
      else if (clr_any) no_to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_shared_div.sv
`timescale 1ns/1ps
module wdog_shared_div
  import wdsd_pkg::*;
#(
  parameter int BASE_TICKS = 18,
  parameter int DIV_W = 8,
  localparam int RATIO_W = $clog2(DIV_W),
  localparam int KW = $clog2(DIV_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wdt_en,
  input  logic               opt_div_to_wdt,
  input  logic [RATIO_W-1:0] opt_ratio,
  input  logic               wdt_tick,
  input  logic               tmr_in_tick,
  input  logic               clr_wdt,
  input  logic               sleep_enter,
  input  logic               in_sleep,
  output logic               tmr_tick_out,
  output logic               wdt_reset,
  output logic               wdt_wake,
  output logic               no_timeout
);
  div_owner_e owner, owner_q;
  logic       owner_chg, clr_any, base_done;
  logic       div_inc, div_clr, div_hit, timeout;
  logic [KW-1:0] div_k;

  assign owner     = div_owner_e'(opt_div_to_wdt);
  assign owner_chg = (owner != owner_q);
  assign clr_any   = clr_wdt | sleep_enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWNER_TIMER;
    else        owner_q <= owner;
  end

  wdsd_base_cnt #(.BASE_TICKS(BASE_TICKS)) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cfg_wdt_en),
    .tick (wdt_tick),
    .clr  (clr_any),
    .done (base_done)
  );

  // Watchdog side counts from 1:1, timer side from 1:2.
  always_comb begin
    if (owner == OWNER_WDOG) div_k = KW'(opt_ratio);
    else                     div_k = KW'(opt_ratio) + KW'(1);
  end

  assign div_inc = !owner_chg &&
                   ((owner == OWNER_WDOG) ? base_done : tmr_in_tick);

  assign timeout = (owner == OWNER_WDOG) ? div_hit : base_done;

  assign div_clr = owner_chg ||
                   ((owner == OWNER_WDOG) && (clr_any || timeout || !cfg_wdt_en));

  wdsd_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (div_inc),
    .clr  (div_clr),
    .k    (div_k),
    .hit  (div_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_tick_out <= 1'b0;
    else        tmr_tick_out <= (owner == OWNER_WDOG) ? tmr_in_tick : div_hit;
  end

  wdsd_timeout_gen u_to (
    .clk       (clk),
    .rst_n     (rst_n),
    .timeout   (timeout),
    .asleep    (in_sleep),
    .clr_any   (clr_any),
    .rst_pulse (wdt_reset),
    .wake_pulse(wdt_wake),
    .no_to_flag(no_timeout)
  );
endmodule

// File: rtl/wdsd_checker.sv
`timescale 1ns/1ps
module wdsd_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_wdt_en,
  input logic opt_div_to_wdt,
  input logic tmr_in_tick,
  input logic clr_wdt,
  input logic sleep_enter,
  input logic in_sleep,
  input logic tmr_tick_out,
  input logic wdt_reset,
  input logic wdt_wake,
  input logic no_timeout
);
  assert_reset_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_wake |=> !wdt_wake);
  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset && wdt_wake));
  assert_reset_when_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> $past(!in_sleep));
  assert_wake_when_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_wake |-> $past(in_sleep));
  assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wdt_en |=> !(wdt_reset || wdt_wake));
  assert_flag_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset || wdt_wake) |-> !no_timeout);
  // R5, R6, R12: a clear restores the flag and blocks a pulse
  assert_clear_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt || sleep_enter) |=> (no_timeout && !wdt_reset && !wdt_wake));
  assert_timer_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_div_to_wdt && tmr_in_tick) |=> tmr_tick_out);
  assert_timer_needs_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_in_tick |=> !tmr_tick_out);
endmodule

bind wdog_shared_div wdsd_checker u_wdsd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wdt_en    (cfg_wdt_en),
  .opt_div_to_wdt(opt_div_to_wdt),
  .tmr_in_tick   (tmr_in_tick),
  .clr_wdt       (clr_wdt),
  .sleep_enter   (sleep_enter),
  .in_sleep      (in_sleep),
  .tmr_tick_out  (tmr_tick_out),
  .wdt_reset     (wdt_reset),
  .wdt_wake      (wdt_wake),
  .no_timeout    (no_timeout)
);

// File: tb/test_wdog_shared_div.sv
`timescale 1ns/1ps
module test_wdog_shared_div;
  localparam int BASE = 4;
  localparam int NV = 10;
  // {kind(0 wdog,1 timer), owner, ratio, expected}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 16'd4},   // R4 1:1
    {1'b0, 1'b1, 3'd1, 16'd8},   // R4 1:2
    {1'b0, 1'b1, 3'd3, 16'd32},  // R4 1:8
    {1'b0, 1'b1, 3'd7, 16'd512}, // R4 1:128
    {1'b0, 1'b0, 3'd5, 16'd4},   // R4 base period, divider on timer
    {1'b0, 1'b0, 3'd0, 16'd4},   // R4
    {1'b1, 1'b0, 3'd0, 16'd32},  // R3 1:2 over 64 events
    {1'b1, 1'b0, 3'd2, 16'd8},   // R3 1:8
    {1'b1, 1'b0, 3'd5, 16'd1},   // R3 1:64
    {1'b1, 1'b1, 3'd3, 16'd64}   // R2 pass-through
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wdt_en = 1'b1, opt_div_to_wdt = 1'b0;
  logic [2:0] opt_ratio = 3'd0;
  logic wdt_tick = 1'b0, tmr_in_tick = 1'b0, clr_wdt = 1'b0;
  logic sleep_enter = 1'b0, in_sleep = 1'b0;
  logic tmr_tick_out, wdt_reset, wdt_wake, no_timeout;
  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  wdog_shared_div #(.BASE_TICKS(BASE)) i_wdog_shared_div (
    .clk(clk), .rst_n(rst_n), .cfg_wdt_en(cfg_wdt_en),
    .opt_div_to_wdt(opt_div_to_wdt), .opt_ratio(opt_ratio),
    .wdt_tick(wdt_tick), .tmr_in_tick(tmr_in_tick), .clr_wdt(clr_wdt),
    .sleep_enter(sleep_enter), .in_sleep(in_sleep),
    .tmr_tick_out(tmr_tick_out), .wdt_reset(wdt_reset),
    .wdt_wake(wdt_wake), .no_timeout(no_timeout)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wtick(); wdt_tick = 1'b1; cyc(); wdt_tick = 1'b0; endtask
  task automatic clr(); clr_wdt = 1'b1; cyc(); clr_wdt = 1'b0; endtask
  task automatic set_owner(input logic o); opt_div_to_wdt = o; cyc(); cyc(); endtask

  task automatic wticks(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      wtick();
      if (wdt_reset || wdt_wake) pulses++;
    end
  endtask

  task automatic run_wdt(output int n, output int wk);
    n = 0; wk = 0;
    for (int i = 1; i <= 2000; i++) begin
      wtick();
      if (wdt_reset || wdt_wake) begin n = i; wk = int'(wdt_wake); break; end
    end
  endtask

  task automatic tmr_run(input int n, output int outs);
    outs = 0;
    tmr_in_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (tmr_tick_out) outs++;
    end
    tmr_in_tick = 1'b0;
  endtask

  initial begin
    int n, wk, p;
    cyc(); cyc(); cyc();
    // R1: reset state
    check("R1 wdt_reset", int'(wdt_reset), 0);
    check("R1 wdt_wake", int'(wdt_wake), 0);
    check("R1 tmr_tick_out", int'(tmr_tick_out), 0);
    check("R1 no_timeout", int'(no_timeout), 1);
    rst_n = 1'b1;
    cyc();

    for (int v = 0; v < NV; v++) begin
      opt_ratio = VEC[v][18:16];
      set_owner(VEC[v][19]);
      clr();
      if (!VEC[v][20]) begin
        run_wdt(n, wk);
        check("R4 ticks to time-out", n, int'(VEC[v][15:0]));
      end else begin
        tmr_run(64, p);
        check(VEC[v][19] ? "R2 timer pass-through" : "R3 timer prescale", p, int'(VEC[v][15:0]));
      end
    end

    // R3: 1:256 boundary
    opt_ratio = 3'd7; set_owner(1'b1); set_owner(1'b0);
    tmr_run(255, p); check("R3 1:256 before last", p, 0);
    tmr_run(1, p);   check("R3 1:256 last event", p, 1);

    // R11: restart after time-out
    opt_ratio = 3'd1; set_owner(1'b1); clr();
    run_wdt(n, wk); check("R11 first period", n, 8);
    run_wdt(n, wk); check("R11 second period", n, 8);
    check("R9 flag after time-out", int'(no_timeout), 0);
    clr();
    check("R9 flag after clear", int'(no_timeout), 1);

    // R5: clear restarts an owned divider
    clr(); wticks(6, p); check("R5 no early pulse", p, 0);
    clr(); run_wdt(n, wk); check("R5 divider cleared", n, 8);

    // R6: sleep entry has the same effect, and restores the flag
    check("R6 flag before", int'(no_timeout), 0);
    wticks(6, p);
    sleep_enter = 1'b1; cyc(); sleep_enter = 1'b0;
    check("R6 flag restored", int'(no_timeout), 1);
    run_wdt(n, wk); check("R6 divider cleared", n, 8);

    // R5: timer-owned divider keeps its partial count
    opt_ratio = 3'd0; set_owner(1'b1); set_owner(1'b0);
    tmr_run(1, p); check("R5 timer first event", p, 0);
    clr();
    tmr_run(1, p); check("R5 timer count kept", p, 1);
    wticks(3, p); clr();
    run_wdt(n, wk); check("R5 base cleared", n, 4);

    // R8: sleep selects wake
    in_sleep = 1'b1; clr();
    run_wdt(n, wk); check("R8 period asleep", n, 4);
    check("R8 wake output", wk, 1);
    check("R9 flag after wake", int'(no_timeout), 0);
    in_sleep = 1'b0;
    run_wdt(n, wk); check("R8 reset output", wk, 0);

    // R7: disabled
    clr(); wticks(2, p);
    cfg_wdt_en = 1'b0;
    wticks(40, p); check("R7 no pulse while disabled", p, 0);
    tmr_run(8, p); check("R7 timer still prescaled", p, 4);
    cfg_wdt_en = 1'b1;
    run_wdt(n, wk); check("R7 fresh period on enable", n, 4);

    // R10: owner change clears the divider
    opt_ratio = 3'd2; set_owner(1'b1); clr();
    wticks(4, p);
    set_owner(1'b0); set_owner(1'b1);
    run_wdt(n, wk); check("R10 divider cleared by change", n, 16);

    // R12: clear beats a same-cycle tick
    opt_ratio = 3'd0; set_owner(1'b0); clr();
    wticks(3, p);
    wdt_tick = 1'b1; clr_wdt = 1'b1; cyc(); wdt_tick = 1'b0; clr_wdt = 1'b0;
    check("R12 no pulse on collision", int'(wdt_reset || wdt_wake), 0);
    cyc();
    check("R12 still no pulse", int'(wdt_reset || wdt_wake), 0);
    run_wdt(n, wk); check("R12 full period after", n, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule